// File: doc/BRIEF.md
# Multiplexed Fluorescent Display Scanner with Key Matrix

This block refreshes a vacuum fluorescent panel one digit at a time. It walks a digit pointer from 0 up to a programmed last digit and then wraps, so 1 to 16 digits can be scanned. Each digit owns one slot of 16 sub-periods. In that slot the digit's timing strobe and its segment pattern are driven. A dimmer setting shortens the lit part of the slot. The segment pattern of the next digit is read from an external display memory during the current slot, so the pattern is ready when that digit's slot begins.

There are eight strobe lines that are always strobes and twelve lines that are always segments. Eight further lines can each be set to carry either a high strobe or a high segment. When the key scan is on, the strobes of the first twelve digits double as the drive lines of a key matrix. Eight return inputs are sampled on each of these strobes. A key map is accepted only after two full frames give the same result. Any accepted change raises an interrupt flag, which stays set until it is cleared.

Top module: `vfd_scan`

## Requirements
- R1: After reset one dark slot passes, then digits 0, 1, ... `cfg_last` are shown in turn, each for one slot, and the sequence wraps back to digit 0.
- R2: A slot is 16 sub-periods of PRESC clocks. The strobe of the current digit is high in sub-periods 0 to 14-`cfg_dim`. Sub-period 15 is always dark.
- R3: The dimmer value `cfg_dim` (0 to 15) darkens that many sub-periods in addition to sub-period 15. At 15 every line stays low for the whole slot.
- R4: The pattern for digit n comes from memory bytes 3n, 3n+1 and 3n+2. Byte 3n drives segments 0-7, byte 3n+1 drives segments 8-15, and the low nibble of byte 3n+2 drives segments 16-19. The read has a one-cycle latency and happens during the slot before the digit is shown.
- R5: Shared line `mix_o[i]` carries segment 19-i when `cfg_mix_seg[i]` is 1. It carries the strobe of digit 8+i when `cfg_mix_seg[i]` is 0.
- R6: Segment lines, including shared lines set to segment use, are driven only while the strobe is lit. They are low in dark sub-periods.
- R7: With `cfg_key_en` high, `key_ret` is sampled at the last clock of sub-period 14 in the slots of digits 0 to 11. Row r lands in `key_map_o[8r+7:8r]`, and bit j holds `key_ret[j]`. Digits 12 to 15 are never sampled.
- R8: `key_map_o` changes only at the end of the last digit's slot, and only when that frame's scan equals the previous frame's scan. A pattern that is present for a single frame is never accepted.
- R9: `key_irq_o` goes high in the cycle after the key map changes. A high `key_irq_clr` clears it on the next edge. When a change and a clear hit the same edge, the flag stays set.
- R10: With `cfg_key_en` low, no samples are taken and the key map keeps its value.
- R11: During reset all strobe and segment lines, the key map and the flag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_last | input | 4 | Index of the last scanned digit (digit count minus one) |
| cfg_dim | input | 4 | Number of extra dark sub-periods per slot |
| cfg_key_en | input | 1 | Enables key-matrix sampling |
| cfg_mix_seg | input | 8 | Per shared line: 1 selects segment use, 0 selects strobe use |
| mem_re | output | 1 | Display memory read strobe |
| mem_addr | output | 6 | Display memory byte address |
| mem_rdata | input | 8 | Display memory data, one cycle after the address |
| tim_o | output | 8 | Strobes of digits 0-7 |
| seg_o | output | 12 | Segments 0-11 |
| mix_o | output | 8 | Shared lines: strobe of digit 8+i or segment 19-i |
| key_ret | input | 8 | Key-matrix return inputs |
| key_map_o | output | 96 | Debounced key map, 8 bits per row |
| key_irq_o | output | 1 | Key-change flag |
| key_irq_clr | input | 1 | Clears the key-change flag |

## Verification
Two things can land on the same clock edge: the key map updating at a frame boundary, which sets the flag, and a clear request. The bench counts slots from reset release to predict the exact edge at which the second matching frame closes. It raises the clear for that single edge and expects the flag to read high one cycle later and to stay high. A second clear, issued away from any frame boundary, must then bring the flag low. This shows that the clear works and that only the collision leaves the flag set.

// File: rtl/vfd_pkg.sv
package vfd_pkg;
  // Sub-periods per digit slot; the last is the inter-digit blank.
  localparam int unsigned SUB_N = 16;
  localparam int unsigned SUB_W = $clog2(SUB_N);

  typedef struct packed {
    logic slot_end; // last clock of the slot
    logic key_pt;   // last clock of the final lit-capable sub-period
    logic active;   // strobe may be lit in this sub-period
  } vfd_tick_t;
endpackage

// File: rtl/vfd_timing.sv
module vfd_timing
  import vfd_pkg::*;
#(
  parameter int unsigned PRESC = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SUB_W-1:0] dim,
  output vfd_tick_t        tick
);
  localparam int unsigned PC_W = (PRESC > 1) ? $clog2(PRESC) : 1;

  logic [PC_W-1:0]  pc_q, pc_d;
  logic [SUB_W-1:0] sp_q, sp_d;
  logic             pc_wrap;

  always_comb begin
    pc_wrap = (pc_q == PC_W'(PRESC - 1));
    pc_d    = pc_wrap ? '0 : pc_q + 1'b1;
    sp_d    = pc_wrap ? sp_q + 1'b1 : sp_q;
    tick.slot_end = pc_wrap && (sp_q == SUB_W'(SUB_N - 1));
    tick.key_pt   = pc_wrap && (sp_q == SUB_W'(SUB_N - 2));
    tick.active   = ({1'b0, sp_q} + {1'b0, dim}) < (SUB_W+1)'(SUB_N - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
      sp_q <= '0;
    end else begin
      pc_q <= pc_d;
      sp_q <= sp_d;
    end
  end

  // R2: the slot end always falls in a dark sub-period
  p_end_dark_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick.slot_end |-> !tick.active);
endmodule

// File: rtl/vfd_fetch.sv
module vfd_fetch #(
  parameter int unsigned DIG_W  = 4,
  parameter int unsigned SEG_W  = 20,
  parameter int unsigned BPD    = 3,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned NDIG   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_end,
  input  logic [DIG_W-1:0]  nxt_dig,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic [SEG_W-1:0]  pattern
);
  localparam int unsigned FC_W = $clog2(BPD + 1);
  localparam int unsigned WIDE = BPD * 8;

  logic [FC_W-1:0]  fc_q, fc_d, idx_q;
  logic             rd_q;
  logic [SEG_W-1:0] pat_q, pat_d;
  logic [WIDE-1:0]  wide;

  always_comb begin
    mem_re   = (fc_q < FC_W'(BPD));
    mem_addr = ADDR_W'(nxt_dig) * ADDR_W'(BPD) + ADDR_W'(fc_q);
    if (slot_end)    fc_d = '0;
    else if (mem_re) fc_d = fc_q + 1'b1;
    else             fc_d = fc_q;
    wide = WIDE'(pat_q);
    if (rd_q) wide[idx_q*8 +: 8] = mem_rdata;
    pat_d = wide[SEG_W-1:0];
  end

  generate
    if (WIDE > SEG_W) begin : g_pad
      logic unused_pad;
      assign unused_pad = ^wide[WIDE-1:SEG_W];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fc_q  <= '0;
      idx_q <= '0;
      rd_q  <= 1'b0;
      pat_q <= '0;
    end else begin
      fc_q  <= fc_d;
      idx_q <= fc_q;
      rd_q  <= mem_re;
      pat_q <= pat_d;
    end
  end

  assign pattern = pat_q;

  // R4: every read stays inside the display memory
  p_addr_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> (int'(mem_addr) < NDIG * BPD));
  // R4: the next digit's bytes are all captured before the slot closes
  p_fetch_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end |-> (fc_q == FC_W'(BPD)) && !rd_q);
endmodule

// File: rtl/vfd_keyscan.sv
module vfd_keyscan #(
  parameter int unsigned KROWS = 12,
  parameter int unsigned KCOLS = 8,
  parameter int unsigned DIG_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sample,
  input  logic [DIG_W-1:0]       row,
  input  logic [KCOLS-1:0]       kret,
  input  logic                   frame_end,
  input  logic                   irq_clr,
  output logic [KROWS*KCOLS-1:0] key_map,
  output logic                   irq
);
  localparam int unsigned MAP_W = KROWS * KCOLS;

  logic [MAP_W-1:0] scan_q, scan_d, prev_q, prev_d, deb_q, deb_d;
  logic             irq_q, irq_d, chg;

  generate
    for (genvar r = 0; r < KROWS; r++) begin : g_row
      assign scan_d[r*KCOLS +: KCOLS] =
        (sample && (row == DIG_W'(r))) ? kret : scan_q[r*KCOLS +: KCOLS];
    end
  endgenerate

  always_comb begin
    chg    = frame_end && (scan_q == prev_q) && (scan_q != deb_q);
    prev_d = frame_end ? scan_q : prev_q;
    deb_d  = chg ? scan_q : deb_q;
    irq_d  = chg | (irq_q & ~irq_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scan_q <= '0;
      prev_q <= '0;
      deb_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      scan_q <= scan_d;
      prev_q <= prev_d;
      deb_q  <= deb_d;
      irq_q  <= irq_d;
    end
  end

  assign key_map = deb_q;
  assign irq     = irq_q;

  // R8: the accepted map moves only on a frame boundary
  p_map_at_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(key_map) |-> $past(frame_end));
  // R8: two different frames never reach the map
  p_debounce_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && (scan_q != prev_q)) |=> $stable(key_map));
  // R9: the flag only rises together with a map change
  p_irq_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> !$stable(key_map));
  // R9: a clear away from a frame boundary drops the flag
  p_irq_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !frame_end) |=> !irq);
endmodule

// File: rtl/vfd_scan.sv
module vfd_scan
  import vfd_pkg::*;
#(
  parameter int unsigned NDIG  = 16,
  parameter int unsigned TLOW  = 8,
  parameter int unsigned NSEG  = 12,
  parameter int unsigned KROWS = 12,
  parameter int unsigned KCOLS = 8,
  parameter int unsigned PRESC = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [3:0]             cfg_last,
  input  logic [3:0]             cfg_dim,
  input  logic                   cfg_key_en,
  input  logic [7:0]             cfg_mix_seg,
  output logic                   mem_re,
  output logic [5:0]             mem_addr,
  input  logic [7:0]             mem_rdata,
  output logic [7:0]             tim_o,
  output logic [11:0]            seg_o,
  output logic [7:0]             mix_o,
  input  logic [7:0]             key_ret,
  output logic [95:0]            key_map_o,
  output logic                   key_irq_o,
  input  logic                   key_irq_clr
);
  localparam int unsigned NMIX   = NDIG - TLOW;
  localparam int unsigned SEG_W  = NSEG + NMIX;
  localparam int unsigned BPD    = (SEG_W + 7) / 8;
  localparam int unsigned DIG_W  = $clog2(NDIG);
  localparam int unsigned ADDR_W = $clog2(NDIG * BPD);

  vfd_tick_t        tick;
  logic [DIG_W-1:0] cur_q, cur_d, nxt_dig;
  logic             valid_q, valid_d;
  logic [SEG_W-1:0] shown_q, shown_d, pattern;
  logic             disp_on, key_smp, frame_end;
  logic [NDIG-1:0]  tline;

  vfd_timing #(.PRESC(PRESC)) u_timing (
    .clk(clk), .rst_n(rst_n), .dim(cfg_dim), .tick(tick)
  );

  vfd_fetch #(
    .DIG_W(DIG_W), .SEG_W(SEG_W), .BPD(BPD), .ADDR_W(ADDR_W), .NDIG(NDIG)
  ) u_fetch (
    .clk(clk), .rst_n(rst_n), .slot_end(tick.slot_end), .nxt_dig(nxt_dig),
    .mem_re(mem_re), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .pattern(pattern)
  );

  // Digit pointer: the dark priming slot after reset is followed by digit 0.
  always_comb begin
    nxt_dig = (!valid_q || (cur_q >= cfg_last)) ? '0 : cur_q + 1'b1;
    cur_d   = cur_q;
    valid_d = valid_q;
    shown_d = shown_q;
    if (tick.slot_end) begin
      cur_d   = nxt_dig;
      valid_d = 1'b1;
      shown_d = pattern;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q   <= '0;
      valid_q <= 1'b0;
      shown_q <= '0;
    end else begin
      cur_q   <= cur_d;
      valid_q <= valid_d;
      shown_q <= shown_d;
    end
  end

  assign disp_on = valid_q && tick.active;
  assign tline   = disp_on ? (NDIG'(1) << cur_q) : '0;
  assign tim_o   = tline[TLOW-1:0];
  assign seg_o   = disp_on ? shown_q[NSEG-1:0] : '0;

  generate
    for (genvar i = 0; i < NMIX; i++) begin : g_mix
      assign mix_o[i] = cfg_mix_seg[i] ? (disp_on & shown_q[SEG_W-1-i])
                                       : tline[TLOW+i];
    end
  endgenerate

  assign key_smp   = tick.key_pt && valid_q && cfg_key_en && (32'(cur_q) < KROWS);
  assign frame_end = tick.slot_end && valid_q && (cur_q >= cfg_last);

  vfd_keyscan #(.KROWS(KROWS), .KCOLS(KCOLS), .DIG_W(DIG_W)) u_keys (
    .clk(clk), .rst_n(rst_n), .sample(key_smp), .row(cur_q), .kret(key_ret),
    .frame_end(frame_end), .irq_clr(key_irq_clr),
    .key_map(key_map_o), .irq(key_irq_o)
  );

  // R2: outputs are dark in the inter-digit blank
  p_gap_dark_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick.slot_end |-> (tim_o == '0) && (seg_o == '0) && (mix_o == '0));
  // R6: no segment shows while the timing says dark
  p_seg_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !tick.active |-> (seg_o == '0));
  // R1: at most one strobe is lit
  p_one_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mix_o & ~cfg_mix_seg, tim_o}));
endmodule

// File: tb/tb_vfd_scan.sv
module tb_vfd_scan;
  localparam int PRESC = 2;
  localparam int L     = 16 * PRESC;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  cfg_last, cfg_dim;
  logic        cfg_key_en;
  logic [7:0]  cfg_mix;
  logic        mem_re;
  logic [5:0]  mem_addr;
  logic [7:0]  mem_rdata;
  logic [7:0]  tim_o;
  logic [11:0] seg_o;
  logic [7:0]  mix_o;
  logic [7:0]  key_ret;
  logic [95:0] key_map;
  logic        key_irq, key_clr;

  logic [7:0]  mem  [48];
  logic [7:0]  kmat [16];
  int cyc, n_chk = 0, n_fail = 0, wd = 0;
  int g_n, g_dim;
  logic [7:0] g_mix;

  typedef struct {
    int          cyc;
    string       req;
    bit          cd;
    logic [7:0]  t;
    logic [11:0] s;
    logic [7:0]  m;
    bit          ck;
    logic        irq;
    logic [95:0] key;
  } item_t;
  item_t q[$];

  always #5 clk = ~clk;

  vfd_scan #(.PRESC(PRESC)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_last(cfg_last), .cfg_dim(cfg_dim),
    .cfg_key_en(cfg_key_en), .cfg_mix_seg(cfg_mix), .mem_re(mem_re),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .tim_o(tim_o), .seg_o(seg_o),
    .mix_o(mix_o), .key_ret(key_ret), .key_map_o(key_map),
    .key_irq_o(key_irq), .key_irq_clr(key_clr)
  );

  initial for (int a = 0; a < 48; a++) mem[a] = 8'(a * 29 + 7);
  always @(posedge clk) mem_rdata <= mem[mem_addr];

  // Key matrix: a return line is pulled by every pressed key on a lit strobe.
  always_comb begin
    key_ret = '0;
    for (int r = 0; r < 8; r++) begin
      if (tim_o[r]) key_ret = key_ret | kmat[r];
      if (!g_mix[r] && mix_o[r]) key_ret = key_ret | kmat[r+8];
    end
  end

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", wd);
      summary();
      $finish;
    end
  end

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: compare every queued expectation in its cycle.
  always @(negedge clk) begin
    int k;
    k = 0;
    if (rst_n) begin
      while (k < q.size()) begin
        if (q[k].cyc == cyc) begin
          if (q[k].cd) chk(q[k].req, {tim_o, seg_o, mix_o}, {q[k].t, q[k].s, q[k].m});
          if (q[k].ck) chk(q[k].req, {key_irq, key_map}, {q[k].irq, q[k].key});
          q.delete(k);
        end else k++;
      end
    end
  end

  // Model of the display lines after c edges since reset release.
  task automatic push_disp(int c, string req);
    item_t it;
    int sl, sp, d;
    logic act;
    logic [19:0] sg;
    logic [15:0] tl;
    it = '{cyc: c, req: req, cd: 1'b1, t: '0, s: '0, m: '0, ck: 1'b0, irq: 1'b0, key: '0};
    sl = c / L;
    sp = (c % L) / PRESC;
    if (sl > 0) begin
      d   = (sl - 1) % g_n;
      act = (sp < 15 - g_dim);
      sg  = {mem[3*d+2][3:0], mem[3*d+1], mem[3*d]};
      tl  = act ? (16'd1 << d) : 16'd0;
      it.t = tl[7:0];
      it.s = act ? sg[11:0] : 12'd0;
      for (int i = 0; i < 8; i++)
        it.m[i] = g_mix[i] ? (act & sg[19-i]) : tl[8+i];
    end
    q.push_back(it);
  endtask

  task automatic push_key(int c, logic irq, logic [95:0] key, string req);
    item_t it;
    it = '{cyc: c, req: req, cd: 1'b0, t: '0, s: '0, m: '0, ck: 1'b1, irq: irq, key: key};
    q.push_back(it);
  endtask

  task automatic wait_cyc(int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic start(int last, int dim, bit ken, logic [7:0] mix);
    rst_n = 1'b0;
    key_clr = 1'b0;
    cfg_last = 4'(last);
    cfg_dim = 4'(dim);
    cfg_key_en = ken;
    cfg_mix = mix;
    g_n = last + 1;
    g_dim = dim;
    g_mix = mix;
    for (int r = 0; r < 16; r++) kmat[r] = '0;
    repeat (2) @(negedge clk);
    chk("R11 reset state", {key_irq, key_map, tim_o, seg_o, mix_o}, '0);
    rst_n = 1'b1;
  endtask

  task automatic finish_run(int last_c);
    wait_cyc(last_c + 1);
    foreach (q[k]) begin
      n_chk++; n_fail++;
      $display("FAIL %s: actual unchecked expected check at cycle %0d", q[k].req, q[k].cyc);
    end
    q.delete();
  endtask

  initial begin
    logic [95:0] kk;
    // Run A: four digits, no dimming, all shared lines as strobes.
    start(3, 0, 1'b0, 8'h00);
    push_disp(5, "R1 priming slot dark");
    for (int s = 1; s <= 9; s++) push_disp(s*L + 3*PRESC, "R1 R4 digit order and data");
    for (int s = 1; s <= 2; s++) begin
      push_disp(s*L + 14*PRESC + 1, "R2 last lit sub-period");
      push_disp(s*L + 15*PRESC, "R2 R6 blank sub-period");
    end
    finish_run(10*L);

    // Run B: one digit, dimmer 5, upper shared lines as segments.
    start(0, 5, 1'b0, 8'hF0);
    for (int s = 1; s <= 4; s++) begin
      push_disp(s*L + 9*PRESC + 1, "R3 R5 lit before dim cut");
      push_disp(s*L + 10*PRESC, "R3 R6 dark after dim cut");
    end
    finish_run(5*L);

    // Run C: dimmer at maximum, low shared lines as segments.
    start(1, 15, 1'b0, 8'h0F);
    for (int s = 1; s <= 3; s++) push_disp(s*L + 1, "R3 full dimming dark");
    finish_run(4*L);

    // Run D: debounce, flag, clear and set-versus-clear collision.
    start(3, 0, 1'b1, 8'h00);
    kk = 96'h81 << 16;
    push_key(289, 1'b0, '0, "R8 single frame not accepted");
    push_key(415, 1'b0, '0, "R8 before second frame end");
    push_key(416, 1'b1, kk, "R7 R8 R9 accepted after two frames");
    push_key(421, 1'b0, kk, "R9 clear");
    push_key(544, 1'b0, kk, "R8 release needs two frames");
    push_key(672, 1'b1, '0, "R9 set wins over clear");
    push_key(673, 1'b1, '0, "R9 flag held");
    push_key(680, 1'b0, '0, "R9 clear after collision");
    push_key(930, 1'b0, '0, "R8 one-frame bounce rejected");
    wait_cyc(160); kmat[2] = 8'h81;
    wait_cyc(417); kmat[2] = 8'h00;
    wait_cyc(420); key_clr = 1'b1;
    wait_cyc(421); key_clr = 1'b0;
    wait_cyc(671); key_clr = 1'b1;
    wait_cyc(672); key_clr = 1'b0;
    wait_cyc(673); kmat[1] = 8'h10;
    wait_cyc(679); key_clr = 1'b1;
    wait_cyc(680); key_clr = 1'b0;
    wait_cyc(800); kmat[1] = 8'h00;
    finish_run(931);

    // Run E: key scan disabled.
    start(3, 0, 1'b0, 8'h00);
    kmat[0] = 8'hFF;
    push_key(14*L, 1'b0, '0, "R10 scan disabled keeps map");
    finish_run(14*L);

    // Run F: sixteen digits, rows above 11 ignored, wrap after digit 15.
    start(15, 0, 1'b1, 8'h00);
    kmat[13] = 8'hFF;
    kmat[11] = 8'h02;
    for (int s = 1; s <= 17; s++) push_disp(s*L + 4*PRESC, "R1 R5 sixteen digit scan");
    push_key(33*L - 1, 1'b0, '0, "R8 before second frame");
    push_key(33*L + 1, 1'b1, 96'h02 << 88, "R7 row 11 kept row 13 ignored");
    finish_run(34*L);

    summary();
    $finish;
  end
endmodule